// File: doc/BRIEF.md
# Successive Approximation Converter Controller

This block is the digital half of an 8-bit successive-approximation analog-to-digital converter. It runs from a free-running clock. It sends a trial code to an external D-to-A converter. An external comparator returns one bit that says whether that trial is higher than the analog input. The controller runs a binary search. It starts at the most significant bit and settles one bit per clock until the whole code is known.

A conversion is framed by a level-held `start` input. The source raises `start` once the analog input is valid and keeps it high. When the last bit is settled, the controller loads the result register and raises `eoc`. `eoc` stays high until `start` falls. The machine then clears `eoc` and returns to its idle state, where it waits for the next rising request.

Top module: `sar_ctrl`

## Requirements
- R1: When `rst` is sampled high on a rising clock edge, the block enters idle with `trial_code` = 0, `result` = 0 and `eoc` = 0.
- R2: When `start` is high in idle, the next edge loads `trial_code` with only its most significant bit set (1000_0000).
- R3: During conversion, an edge with `over_under` = 1 (trial above the input) clears the bit under test.
- R4: During conversion, an edge with `over_under` = 0 (trial at or below the input) keeps the bit under test at 1. On every conversion edge except the last, the next lower bit is set to 1 for the next trial.
- R5: Bits are decided from the most significant down to the least significant, one per edge. `eoc` rises on the 8th edge after the edge that loaded the first trial. For an integer input v in 0..255, `result` then equals v.
- R6: `result` changes only on the edge where `eoc` rises. It holds its value through the wait for `start` to fall, through idle, and through the whole next conversion.
- R7: `eoc` stays high while `start` stays high. It falls on the first edge that samples `start` low.
- R8: While `eoc` is high and `start` remains high, no new conversion begins and `trial_code` stays unchanged.
- R9: In idle with `start` low, `trial_code`, `result` and `eoc` (low) stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Conversion request, held high for the whole conversion |
| over_under | input | 1 | Comparator bit: 1 when the trial code is above the analog input |
| trial_code | output | 8 | Trial code sent to the D-to-A converter |
| result | output | 8 | Final converted code |
| eoc | output | 1 | End of conversion, valid result |

## Verification
The comparator is modelled as a strict integer comparison against the trial code. Conversions are run for the range ends 0 and 255 and for the midpoint pair 127 and 128, which separate a trial that equals the input from one just above it. The alternating patterns 0x55 and 0xAA, and the values 1 and 200, make every bit position take both the keep and the clear decision. Each conversion checks every intermediate trial code against a reference search. It also holds `start` past `eoc` to show that no restart occurs, and it waits in idle to show that the result is held.

// File: rtl/sar_pkg.sv
package sar_pkg;

    localparam int DEF_WIDTH = 8;

    typedef enum logic [1:0] {
        ST_READY = 2'd0,
        ST_CONV  = 2'd1,
        ST_DONE  = 2'd2
    } sar_state_e;

    typedef struct packed {
        logic load_first;
        logic step;
        logic last;
    } sar_ctl_t;

endpackage

// File: rtl/sar_fsm.sv
module sar_fsm
    import sar_pkg::*;
#(
    parameter int WIDTH = DEF_WIDTH,
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output sar_state_e       state_q,
    output logic [IDX_W-1:0] bit_idx,
    output sar_ctl_t         ctl,
    output logic             eoc
);

    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(WIDTH - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_READY;
            bit_idx <= '0;
            eoc     <= 1'b0;
        end else begin
            case (state_q)
                ST_READY: begin
                    if (start) begin
                        state_q <= ST_CONV;
                        bit_idx <= TOP_IDX;
                    end
                end
                ST_CONV: begin
                    if (bit_idx == '0) begin
                        state_q <= ST_DONE;
                        eoc     <= 1'b1;
                    end else begin
                        bit_idx <= bit_idx - 1'b1;
                    end
                end
                ST_DONE: begin
                    if (!start) begin
                        state_q <= ST_READY;
                        eoc     <= 1'b0;
                    end
                end
                default: begin
                    state_q <= ST_READY;
                    eoc     <= 1'b0;
                end
            endcase
        end
    end

    always_comb begin
        ctl.load_first = (state_q == ST_READY) && start;
        ctl.step       = (state_q == ST_CONV);
        ctl.last       = (state_q == ST_CONV) && (bit_idx == '0);
    end

endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg
    import sar_pkg::*;
#(
    parameter int WIDTH = DEF_WIDTH,
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  sar_ctl_t         ctl,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             over_under,
    output logic [WIDTH-1:0] trial_q,
    output logic [WIDTH-1:0] result_q
);

    logic [WIDTH-1:0] trial_d;

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        always_comb begin
            if (ctl.load_first) begin
                trial_d[g] = (g == WIDTH - 1);
            end else if (ctl.step) begin
                if (int'(bit_idx) == g) begin
                    trial_d[g] = !over_under;
                end else if (int'(bit_idx) == g + 1) begin
                    trial_d[g] = 1'b1;
                end else begin
                    trial_d[g] = trial_q[g];
                end
            end else begin
                trial_d[g] = trial_q[g];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trial_q  <= '0;
            result_q <= '0;
        end else begin
            trial_q <= trial_d;
            if (ctl.last) begin
                result_q <= trial_d;
            end
        end
    end

endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
    import sar_pkg::*;
#(
    parameter int WIDTH = DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             over_under,
    output logic [WIDTH-1:0] trial_code,
    output logic [WIDTH-1:0] result,
    output logic             eoc
);

    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;

    sar_state_e       state_q;
    logic [IDX_W-1:0] bit_idx;
    sar_ctl_t         ctl;

    sar_fsm #(.WIDTH(WIDTH)) fsm_i (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .state_q (state_q),
        .bit_idx (bit_idx),
        .ctl     (ctl),
        .eoc     (eoc)
    );

    sar_trial_reg #(.WIDTH(WIDTH)) reg_i (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .bit_idx    (bit_idx),
        .over_under (over_under),
        .trial_q    (trial_code),
        .result_q   (result)
    );

endmodule

// File: rtl/sar_ctrl_chk.sv
module sar_ctrl_chk
    import sar_pkg::*;
#(
    parameter int WIDTH = DEF_WIDTH,
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             over_under,
    input logic [WIDTH-1:0] trial_code,
    input logic [WIDTH-1:0] result,
    input logic             eoc,
    input sar_state_e       state_q,
    input logic [IDX_W-1:0] bit_idx
);

    logic [IDX_W-1:0] idx_d;
    always_ff @(posedge clk) idx_d <= bit_idx;

    // R1
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (trial_code == '0 && result == '0 && !eoc));

    // R2
    p_first_trial_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_READY && start) |=> trial_code == {1'b1, {(WIDTH-1){1'b0}}});

    // R3
    p_clear_above_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CONV && over_under) |=> !trial_code[idx_d]);

    // R4
    p_keep_below_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CONV && !over_under) |=> trial_code[idx_d]);

    // R4
    p_next_lower_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CONV && bit_idx != '0) |=> trial_code[idx_d - 1'b1]);

    // R6
    p_result_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(result) |-> $rose(eoc));

    // R7
    p_eoc_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (eoc && start) |=> eoc);

    // R7
    p_eoc_drop_r7: assert property (@(posedge clk) disable iff (rst)
        (eoc && !start) |=> !eoc);

    // R8
    p_no_restart_r8: assert property (@(posedge clk) disable iff (rst)
        (eoc && start) |=> $stable(trial_code));

    // R9
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_READY && !start) |=> ($stable(trial_code) && !eoc));

endmodule

bind sar_ctrl sar_ctrl_chk #(.WIDTH(WIDTH)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .over_under (over_under),
    .trial_code (trial_code),
    .result     (result),
    .eoc        (eoc),
    .state_q    (state_q),
    .bit_idx    (bit_idx)
);

// File: tb/sar_ctrl_tb_top.sv
module sar_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       over_under;
    logic [7:0] trial_code;
    logic [7:0] result;
    logic       eoc;
    int         vin = 0;
    int         n_checks = 0;
    int         n_fails = 0;
    logic [7:0] prev_result = 8'h00;

    always #10 clk = ~clk;

    assign over_under = (int'(trial_code) > vin);

    sar_ctrl dut_i (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .over_under (over_under),
        .trial_code (trial_code),
        .result     (result),
        .eoc        (eoc)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        start = 1'b0;
        repeat (3) @(negedge clk);
        check(trial_code == 8'h00, "R1 trial", trial_code, 0);
        check(result == 8'h00, "R1 result", result, 0);
        check(eoc == 1'b0, "R1 eoc", eoc, 0);
        rst = 1'b0;
        prev_result = 8'h00;
        @(negedge clk);
    endtask

    task automatic t_convert(input int v);
        logic [7:0] exp_code;
        vin = v;
        start = 1'b1;
        @(negedge clk);
        check(trial_code == 8'h80, "R2 first trial", trial_code, 8'h80);
        exp_code = 8'h80;
        for (int i = 7; i >= 0; i--) begin
            bit above;
            above = int'(exp_code) > v;
            if (above) exp_code[i] = 1'b0;
            if (i > 0) exp_code[i-1] = 1'b1;
            @(negedge clk);
            if (above) check(trial_code == exp_code, "R3 clear step", trial_code, exp_code);
            else       check(trial_code == exp_code, "R4 keep step", trial_code, exp_code);
            if (i > 0) begin
                check(eoc == 1'b0, "R5 eoc early", eoc, 0);
                check(result == prev_result, "R6 result held in conversion", result, prev_result);
            end
        end
        check(eoc == 1'b1, "R5 eoc timing", eoc, 1);
        check(result == 8'(v), "R5 result value", result, v);
        prev_result = result;
        repeat (3) begin
            @(negedge clk);
            check(eoc == 1'b1, "R7 eoc held", eoc, 1);
            check(trial_code == exp_code, "R8 no restart", trial_code, exp_code);
        end
        start = 1'b0;
        @(negedge clk);
        check(eoc == 1'b0, "R7 eoc cleared", eoc, 0);
        repeat (3) begin
            @(negedge clk);
            check(trial_code == exp_code, "R9 idle trial", trial_code, exp_code);
            check(eoc == 1'b0, "R9 idle eoc", eoc, 0);
            check(result == prev_result, "R6 result held in idle", result, prev_result);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_convert(0);
        t_convert(255);
        t_convert(128);
        t_convert(127);
        t_convert(8'h55);
        t_convert(8'hAA);
        t_convert(1);
        t_convert(200);
        t_reset();
        t_convert(77);
        summary();
        $finish;
    end

endmodule